// File: doc/BRIEF.md
# Multi-Port MIDI Data-Channel Multiplexer

This block carries MIDI bytes for three ports over the first 32-bit data channel of every audio data block. The ports are two physical ports and a console port. On the transmit side, each port has a small byte FIFO with a valid/ready handshake. When the framer asks for the next data block, the block serves one port and builds a quadlet with up to two of that port's bytes. On the receive side, each incoming quadlet is decoded and its bytes are delivered, tagged with the port they belong to.

The quadlet layout is fixed:

| Bits | Content |
|------|---------|
| 31:24 | Constant marker 0x80 |
| 23:16 | First MIDI byte |
| 15:8 | Second MIDI byte |
| 7:4 | Port code |
| 3:0 | Byte count |

The port codes are 0x0 for port index 0, 0x2 for port index 1 and 0xE for port index 2 (the console port). Console traffic shares the channel with the physical ports and is told apart only by its code. The block does not interpret MIDI messages. It moves only bytes.

Top module: `midi_chan_mux`

## Requirements
- R1: After reset, `tx_quad` is 0 and `tx_quad_valid`, `rx_valid` and `rx_err` are 0. Every `tx_in_ready` bit is 1.
- R2: A transmitted quadlet carries 0x80 in bits 31:24, the first byte in 23:16 and the second byte in 15:8. Bits 7:4 hold the port code (0x0, 0x2 or 0xE for port index 0, 1 or 2) and bits 3:0 hold the byte count. With a count of 1, bits 15:8 are zero.
- R3: When every FIFO is empty at a block request, the quadlet is 0x80000000.
- R4: A quadlet takes at most two bytes, all from one port. It takes two bytes when that port holds two or more. Bytes leave each port in the order they were accepted.
- R5: Ports are served round robin. The search starts at the port after the last one served, skips empty ports and wraps from index 2 to index 0. An idle block does not move the search start.
- R6: Each port FIFO holds 8 bytes. `tx_in_ready` drops while 8 bytes are held. A byte offered while ready is low is not stored.
- R7: A received quadlet with marker 0x80, a known code and a count of 1 or 2 sets the one-hot `rx_valid` bit of its port one cycle later. In that same cycle `rx_data` holds {bits 23:16, bits 15:8} and `rx_count` holds the count. With a count of 1, `rx_data[7:0]` is zero.
- R8: A well-formed quadlet with a count of 0 produces no `rx_valid` and no `rx_err`.
- R9: A received quadlet is dropped and `rx_err` pulses for one cycle, with `rx_valid` at zero, when any of these holds: the code is unknown, the count is above 2, or the marker is not 0x80.
- R10: `tx_quad_valid` is high exactly in the cycle after a `blk_strobe`. `tx_quad` keeps its value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_data | input | NPORT*8 | Byte offered to each port, port p in bits 8p+7:8p |
| tx_in_valid | input | NPORT | Byte offer per port |
| tx_in_ready | output | NPORT | Port FIFO can take a byte |
| blk_strobe | input | 1 | Build the MIDI quadlet for the next data block |
| tx_quad | output | 32 | Formatted outgoing quadlet |
| tx_quad_valid | output | 1 | `tx_quad` was built in the previous cycle |
| rx_quad | input | 32 | Incoming first-channel quadlet |
| rx_quad_valid | input | 1 | `rx_quad` is present |
| rx_valid | output | NPORT | One-hot port that received bytes |
| rx_data | output | 16 | Received bytes, first byte in bits 15:8 |
| rx_count | output | 2 | Number of valid received bytes |
| rx_err | output | 1 | Malformed quadlet dropped |

## Verification
The hardest case to reach from the ports is the arbiter meeting every mix of queue depths with its round-robin start pointer in each of its positions. Several ports hold one byte, others hold three, and the pointer must skip an empty port or wrap.

The bench fills the three FIFOs with every combination of 0 to 3 bytes and drains them one block at a time. It keeps its own queues and pointer, so the start position carried between combinations keeps changing. A separate sequence fills one port to its limit and offers one more byte. The receive side is swept over all 256 code/count pairs, plus a few quadlets with a bad marker.

// File: rtl/midi_chan_pkg.sv
package midi_chan_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned QUAD_W      = 32;
   localparam int unsigned MAX_PER_BLK = 2;
   localparam logic [7:0]  CHAN_MARKER = 8'h80;

   // Port index to the code carried in bits 7:4 of the quadlet.
   function automatic logic [3:0] port_code(input int idx);
      case (idx)
         0:       port_code = 4'h0;
         1:       port_code = 4'h2;
         default: port_code = 4'hE;
      endcase
   endfunction
endpackage

// File: rtl/midi_byte_fifo.sv
module midi_byte_fifo #(
   parameter int unsigned DEPTH = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [7:0]                    in_data,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [1:0]                    pop_n,
   output logic [7:0]                    head0,
   output logic [7:0]                    head1,
   output logic [$clog2(DEPTH+1)-1:0]    level
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH+1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("midi_byte_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push;

   assign in_ready = (level != LW'(DEPTH));
   assign push     = in_valid && in_ready;
   assign head0    = mem[rd_ptr];
   assign head1    = mem[rd_ptr + AW'(1)];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         rd_ptr <= rd_ptr + AW'(pop_n);
         level  <= level + LW'(push) - LW'(pop_n);
      end
   end
endmodule

// File: rtl/midi_tx_arb.sv
module midi_tx_arb
   import midi_chan_pkg::*;
#(
   parameter int unsigned NPORT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  blk_strobe,
   input  logic [NPORT-1:0]      has1,
   input  logic [NPORT-1:0]      has2,
   input  logic [NPORT*8-1:0]    head0,
   input  logic [NPORT*8-1:0]    head1,
   output logic [NPORT*2-1:0]    pop_n,
   output logic [QUAD_W-1:0]     tx_quad,
   output logic                  tx_quad_valid
);
   localparam int unsigned PW = (NPORT > 1) ? $clog2(NPORT) : 1;

   logic [PW-1:0] ptr, sel, sel_next;
   logic          found;
   logic [1:0]    cnt;
   logic [7:0]    b0, b1;

   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int k = 0; k < int'(NPORT); k++) begin
         int j;
         j = int'(ptr) + k;
         if (j >= int'(NPORT)) j = j - int'(NPORT);
         if (!found && has1[j]) begin
            found = 1'b1;
            sel   = PW'(j);
         end
      end
      cnt      = has2[sel] ? 2'd2 : 2'd1;
      b0       = head0[sel*8 +: 8];
      b1       = (cnt == 2'd2) ? head1[sel*8 +: 8] : 8'h00;
      sel_next = (int'(sel) == int'(NPORT) - 1) ? '0 : sel + PW'(1);
      pop_n    = '0;
      if (blk_strobe && found) pop_n[sel*2 +: 2] = cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr           <= '0;
         tx_quad       <= '0;
         tx_quad_valid <= 1'b0;
      end else begin
         tx_quad_valid <= blk_strobe;
         if (blk_strobe) begin
            if (found) begin
               tx_quad <= {CHAN_MARKER, b0, b1, port_code(int'(sel)), 2'b00, cnt};
               ptr     <= sel_next;
            end else begin
               tx_quad <= {CHAN_MARKER, 24'h000000};
            end
         end
      end
   end
endmodule

// File: rtl/midi_rx_dec.sv
module midi_rx_dec
   import midi_chan_pkg::*;
#(
   parameter int unsigned NPORT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [QUAD_W-1:0]  rx_quad,
   input  logic               rx_quad_valid,
   output logic [NPORT-1:0]   rx_valid,
   output logic [15:0]        rx_data,
   output logic [1:0]         rx_count,
   output logic               rx_err
);
   logic [NPORT-1:0] hit;
   logic [3:0]       n;
   logic             bad, carry;

   always_comb begin
      n = rx_quad[3:0];
      for (int p = 0; p < int'(NPORT); p++)
         hit[p] = (port_code(p) == rx_quad[7:4]);
      bad   = (hit == '0) || (n > 4'd2) || (rx_quad[31:24] != CHAN_MARKER);
      carry = rx_quad_valid && !bad && (n != 4'd0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_valid <= '0;
         rx_data  <= '0;
         rx_count <= '0;
         rx_err   <= 1'b0;
      end else begin
         rx_err   <= rx_quad_valid && bad;
         rx_valid <= carry ? hit : '0;
         rx_count <= carry ? n[1:0] : 2'd0;
         rx_data  <= carry ? {rx_quad[23:16], (n == 4'd2) ? rx_quad[15:8] : 8'h00}
                           : 16'h0000;
      end
   end
endmodule

// File: rtl/midi_chan_mux.sv
module midi_chan_mux
   import midi_chan_pkg::*;
#(
   parameter int unsigned NPORT      = 3,
   parameter int unsigned FIFO_DEPTH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORT*8-1:0]   tx_in_data,
   input  logic [NPORT-1:0]     tx_in_valid,
   output logic [NPORT-1:0]     tx_in_ready,
   input  logic                 blk_strobe,
   output logic [31:0]          tx_quad,
   output logic                 tx_quad_valid,
   input  logic [31:0]          rx_quad,
   input  logic                 rx_quad_valid,
   output logic [NPORT-1:0]     rx_valid,
   output logic [15:0]          rx_data,
   output logic [1:0]           rx_count,
   output logic                 rx_err
);
   localparam int unsigned LW = $clog2(FIFO_DEPTH+1);

   if (NPORT < 2 || NPORT > 3) begin : g_bad_nport
      $error("midi_chan_mux: NPORT must be 2 or 3");
   end

   logic [NPORT-1:0]   has1, has2;
   logic [NPORT*8-1:0] head0, head1;
   logic [NPORT*2-1:0] pop_n;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [LW-1:0] level;
      midi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_data  (tx_in_data[p*8 +: 8]),
         .in_valid (tx_in_valid[p]),
         .in_ready (tx_in_ready[p]),
         .pop_n    (pop_n[p*2 +: 2]),
         .head0    (head0[p*8 +: 8]),
         .head1    (head1[p*8 +: 8]),
         .level    (level)
      );
      assign has1[p] = (level >= LW'(1));
      assign has2[p] = (level >= LW'(2));
   end

   midi_tx_arb #(.NPORT(NPORT)) u_arb (
      .clk           (clk),
      .rst_n         (rst_n),
      .blk_strobe    (blk_strobe),
      .has1          (has1),
      .has2          (has2),
      .head0         (head0),
      .head1         (head1),
      .pop_n         (pop_n),
      .tx_quad       (tx_quad),
      .tx_quad_valid (tx_quad_valid)
   );

   midi_rx_dec #(.NPORT(NPORT)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_quad       (rx_quad),
      .rx_quad_valid (rx_quad_valid),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .rx_count      (rx_count),
      .rx_err        (rx_err)
   );
endmodule

// File: rtl/midi_chan_mux_chk.sv
module midi_chan_mux_chk #(
   parameter int unsigned NPORT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             blk_strobe,
   input logic [31:0]      tx_quad,
   input logic             tx_quad_valid,
   input logic             rx_quad_valid,
   input logic [NPORT-1:0] rx_valid,
   input logic             rx_err
);
   AST_TX_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      tx_quad_valid |-> tx_quad[31:24] == 8'h80);                             // R2
   AST_TX_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_quad_valid |-> tx_quad[3:0] <= 4'd2);                                // R4
   AST_TX_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      blk_strobe |=> tx_quad_valid);                                          // R10
   AST_TX_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_strobe |=> (!tx_quad_valid && $stable(tx_quad)));                  // R10
   AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rx_valid));                                                    // R7
   AST_RX_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> rx_valid == '0);                                             // R9
   AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_quad_valid |=> (rx_valid == '0 && !rx_err));                        // R7
endmodule

bind midi_chan_mux midi_chan_mux_chk #(.NPORT(NPORT)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .blk_strobe    (blk_strobe),
   .tx_quad       (tx_quad),
   .tx_quad_valid (tx_quad_valid),
   .rx_quad_valid (rx_quad_valid),
   .rx_valid      (rx_valid),
   .rx_err        (rx_err)
);

// File: tb/test_midi_chan_mux.sv
`timescale 1ns/1ps
module test_midi_chan_mux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] tx_in_data = '0;
   logic [2:0]  tx_in_valid = '0;
   logic [2:0]  tx_in_ready;
   logic        blk_strobe = 1'b0;
   logic [31:0] tx_quad;
   logic        tx_quad_valid;
   logic [31:0] rx_quad = '0;
   logic        rx_quad_valid = 1'b0;
   logic [2:0]  rx_valid;
   logic [15:0] rx_data;
   logic [1:0]  rx_count;
   logic        rx_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] mq0[$], mq1[$], mq2[$];
   int rr = 0;
   logic [7:0] seq = 8'h01;

   always #10 clk = ~clk;

   midi_chan_mux i_midi_chan_mux (
      .clk(clk), .rst_n(rst_n),
      .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
      .blk_strobe(blk_strobe), .tx_quad(tx_quad), .tx_quad_valid(tx_quad_valid),
      .rx_quad(rx_quad), .rx_quad_valid(rx_quad_valid),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_count(rx_count), .rx_err(rx_err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int qsize(input int p);
      case (p)
         0: qsize = mq0.size();
         1: qsize = mq1.size();
         default: qsize = mq2.size();
      endcase
   endfunction

   function automatic logic [7:0] qpop(input int p);
      case (p)
         0: qpop = mq0.pop_front();
         1: qpop = mq1.pop_front();
         default: qpop = mq2.pop_front();
      endcase
   endfunction

   task automatic push_byte(input int p, input logic [7:0] b);
      bit rdy;
      @(negedge clk);
      tx_in_data[p*8 +: 8] = b;
      tx_in_valid[p] = 1'b1;
      rdy = tx_in_ready[p];
      @(posedge clk);
      @(negedge clk);
      tx_in_valid[p] = 1'b0;
      if (rdy) begin
         case (p)
            0: mq0.push_back(b);
            1: mq1.push_back(b);
            default: mq2.push_back(b);
         endcase
      end
   endtask

   // Model: R2 R3 R4 R5 R10
   task automatic strobe_check();
      logic [31:0] exp;
      int sel;
      int n;
      logic [7:0] b0, b1;
      sel = -1;
      for (int k = 0; k < 3; k++) begin
         int j;
         j = (rr + k) % 3;
         if (sel < 0 && qsize(j) > 0) sel = j;
      end
      if (sel < 0) begin
         exp = 32'h80000000;
      end else begin
         n  = (qsize(sel) >= 2) ? 2 : 1;
         b0 = qpop(sel);
         b1 = (n == 2) ? qpop(sel) : 8'h00;
         exp = {8'h80, b0, b1, (sel == 0) ? 4'h0 : (sel == 1) ? 4'h2 : 4'hE, 4'(n)};
         rr = (sel + 1) % 3;
      end
      @(negedge clk);
      blk_strobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      blk_strobe = 1'b0;
      chk(tx_quad_valid == 1'b1, "R10 valid after strobe", 64'(tx_quad_valid), 64'd1);
      if (sel < 0)
         chk(tx_quad == exp, "R3 idle quadlet", 64'(tx_quad), 64'(exp));
      else
         chk(tx_quad == exp, "R2 R4 R5 quadlet", 64'(tx_quad), 64'(exp));
   endtask

   task automatic rx_send(input logic [31:0] q);
      int idx;
      int n;
      bit bad;
      logic [2:0]  ev;
      logic [15:0] ed;
      logic [1:0]  ec;
      n   = int'(q[3:0]);
      idx = (q[7:4] == 4'h0) ? 0 : (q[7:4] == 4'h2) ? 1 : (q[7:4] == 4'hE) ? 2 : -1;
      bad = (idx < 0) || (n > 2) || (q[31:24] != 8'h80);
      ev  = (!bad && n != 0) ? 3'(1 << idx) : 3'b000;
      ed  = (!bad && n != 0) ? {q[23:16], (n == 2) ? q[15:8] : 8'h00} : 16'h0000;
      ec  = (!bad && n != 0) ? 2'(n) : 2'd0;
      @(negedge clk);
      rx_quad = q;
      rx_quad_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rx_quad_valid = 1'b0;
      if (bad)
         chk({rx_err, rx_valid} == {1'b1, 3'b000}, "R9 malformed dropped",
             64'({rx_err, rx_valid}), 64'({1'b1, 3'b000}));
      else if (n == 0)
         chk({rx_err, rx_valid, rx_count} == 6'd0, "R8 empty quadlet",
             64'({rx_err, rx_valid, rx_count}), 64'd0);
      else
         chk({rx_err, rx_valid, rx_data, rx_count} == {1'b0, ev, ed, ec}, "R7 routed bytes",
             64'({rx_err, rx_valid, rx_data, rx_count}), 64'({1'b0, ev, ed, ec}));
      @(posedge clk);
      @(negedge clk);
      chk({rx_err, rx_valid} == 4'd0, "R7 one cycle only", 64'({rx_err, rx_valid}), 64'd0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(tx_quad == 32'd0 && !tx_quad_valid, "R1 tx reset", 64'({tx_quad_valid, tx_quad}), 64'd0);
      chk(rx_valid == 3'd0 && !rx_err, "R1 rx reset", 64'({rx_err, rx_valid}), 64'd0);
      chk(tx_in_ready == 3'b111, "R1 ready reset", 64'(tx_in_ready), 64'h7);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 idle block with nothing queued
      strobe_check();
      // R10 hold without strobe
      begin
         logic [31:0] keep;
         keep = tx_quad;
         @(negedge clk);
         chk(!tx_quad_valid && tx_quad == keep, "R10 hold", 64'({tx_quad_valid, tx_quad}),
             64'({1'b0, keep}));
      end

      // R4 R5 sweep over all depth mixes 0..3 per port
      for (int c = 0; c < 64; c++) begin
         for (int p = 0; p < 3; p++) begin
            int cnt;
            cnt = (c >> (2 * p)) & 3;
            for (int i = 0; i < cnt; i++) begin
               push_byte(p, seq);
               seq = seq + 8'd1;
            end
         end
         while (qsize(0) + qsize(1) + qsize(2) > 0) strobe_check();
         strobe_check();
      end

      // R6 fill port 1, offer a ninth byte, then drain in order
      for (int i = 0; i < 8; i++) begin
         push_byte(1, 8'hA0 + 8'(i));
      end
      chk(tx_in_ready == 3'b101, "R6 ready low at 8 bytes", 64'(tx_in_ready), 64'h5);
      push_byte(1, 8'hEE);
      chk(qsize(1) == 8, "R6 ninth byte refused", 64'(qsize(1)), 64'd8);
      chk(tx_in_ready[1] == 1'b0, "R6 still full", 64'(tx_in_ready[1]), 64'd0);
      for (int i = 0; i < 5; i++) strobe_check();
      chk(tx_in_ready == 3'b111, "R6 ready after drain", 64'(tx_in_ready), 64'h7);

      // R7 R8 R9 receive sweep over every code and count
      for (int code = 0; code < 16; code++) begin
         for (int n = 0; n < 16; n++) begin
            rx_send({8'h80, 8'(code * 16 + n), 8'(255 - code * 16 - n), 4'(code), 4'(n)});
         end
      end
      // R9 wrong marker
      rx_send(32'h00123401);
      rx_send(32'h81ABCD22);
      rx_send(32'hFF5566E2);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule